// File: doc/BRIEF.md
# Four-Channel Edge-Triggered External Interrupt Unit

This block watches four asynchronous input pins and turns a chosen transition on each pin into a latched request flag. Every channel has its own enable bit, its own polarity (inversion) bit and its own flag. With the inversion bit at 0, a channel reacts to a falling edge on its pin. With the inversion bit at 1, it reacts to a rising edge. A channel drives its request line to the processor for as long as its flag and its enable bit are both 1. Software clears a flag by writing 0 to that flag bit. A single wake output is the OR of the four request lines, formed without any clocked stage, so it can restart the clocks while they are stopped.

The detector does not look at the raw pin. It looks at a derived level: the synchronised pin, XOR the inversion bit, inverted, then ANDed with the enable bit. A 0-to-1 change of that level counts as an event. Because of this, changing the inversion bit or turning on the enable bit can itself produce an event, depending on the pin level at that moment. Software is expected to make such changes with the request masked and then clear the flag. The register port is a simple single-cycle write strobe with a combinational read.

Top module: `eint_ctrl`

## Requirements
- R1: After a synchronous reset, the enable, inversion and flag bits of every channel are 0, every request output is 0, and the wake output is 0.
- R2: With its inversion bit at 0, an enabled channel sets its flag on a falling edge of its pin. The flag becomes visible 3 clock edges after the pin changes (a two-flop synchroniser, then the flag register). A rising edge sets nothing, and a channel whose enable bit is 0 never sets its flag.
- R3: A write to the flag register clears each flag whose written bit is 0. A written 1 leaves that flag unchanged and never sets it.
- R4: Request line n equals flag n AND enable n. If flag n is already 1 when enable n is written from 0 to 1, the request is asserted in the cycle right after that write. Disabling a channel keeps its flag.
- R5: With its inversion bit at 1, a channel sets its flag on a rising edge of its pin. Writing the inversion bit from 0 to 1 while the pin is high, or from 1 to 0 while the pin is low, sets the flag 2 edges after the write is applied.
- R6: Writing a channel's enable bit from 0 to 1 sets its flag 2 edges after the write when the pin sits at the level that the inversion bit treats as post-edge: low with inversion 0, high with inversion 1.
- R7: The wake output is the OR of the four request lines and depends on no clock edge beyond the ones that update the flag and enable registers.
- R8: When an edge event and a clearing write reach the same flag on the same clock edge, the flag ends up set.
- R9: The register map uses byte offsets. 0x0 holds the enable bits, 0x4 the inversion bits and 0x8 the flags, each in bits [3:0] with bit n belonging to channel n. Reads are combinational. Bits above [3:0] and every other offset read as 0, and written upper bits are dropped.
- R10: Channels are independent. Simultaneous edges on several pins set exactly those channels' flags, and clearing one flag leaves the others as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 4 | Asynchronous external interrupt pins, bit n is channel n |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_o | output | 4 | Per-channel interrupt request |
| wake_o | output | 1 | OR of all request lines, for stop-mode wake-up |

## Verification
A pin change is due at the flag and request outputs on the third rising edge after the change. A register write is due on the edge that accepts it. For enable-on with a held flag, the request follows on that same edge. An inversion or enable write that creates an event sets the flag one edge later. The driver stamps every expected request value with the exact cycle it is due, from these latencies. It also records the value that must still hold one cycle earlier. The monitor compares request and wake lines half a period after that edge, and register reads are sampled between edges once the write has been accepted.

// File: rtl/eint_pkg.sv
`timescale 1ns/1ps
// Package: shared register offsets, select type and address decoder for the
// external edge interrupt unit. Assumes byte-offset addressing on a 4-bit bus.
package eint_pkg;

    localparam int unsigned EINT_ADDR_W = 4;

    localparam logic [EINT_ADDR_W-1:0] OFS_ENABLE = 4'h0;
    localparam logic [EINT_ADDR_W-1:0] OFS_INVERT = 4'h4;
    localparam logic [EINT_ADDR_W-1:0] OFS_FLAG   = 4'h8;

    typedef enum logic [1:0] {
        SEL_ENABLE,
        SEL_INVERT,
        SEL_FLAG,
        SEL_NONE
    } reg_sel_e;

    // Map a byte offset to the register it selects; anything else is SEL_NONE.
    function automatic reg_sel_e decode_addr(input logic [EINT_ADDR_W-1:0] addr);
        reg_sel_e sel;
        case (addr)
            OFS_ENABLE: sel = SEL_ENABLE;
            OFS_INVERT: sel = SEL_INVERT;
            OFS_FLAG:   sel = SEL_FLAG;
            default:    sel = SEL_NONE;
        endcase
        return sel;
    endfunction

endpackage

// File: rtl/eint_sync.sv
`timescale 1ns/1ps
// Module: eint_sync
// Two-flop synchroniser, one chain per channel. Assumes each pin is a slow
// level signal with no relation to clk; output lags the pin by two edges.
module eint_sync #(
    parameter int unsigned NCH    = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] async_i,
    output logic [NCH-1:0] sync_o
);

    localparam int unsigned LAST = STAGES - 1;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [STAGES-1:0] chain_q;

        // Shift the pin level through the synchroniser chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[ch]};
            end
        end

        assign sync_o[ch] = chain_q[LAST];
    end

endmodule

// File: rtl/eint_edge.sv
`timescale 1ns/1ps
// Module: eint_edge
// Per-channel event detector. The observed level is ~(sync ^ invert) & enable,
// so invert=0 catches falling pin edges and invert=1 rising ones. A 0-to-1
// step of that level is an event. Assumes invert/enable come from registers;
// changing them can itself produce an event by design.
module eint_edge #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] sync_i,
    input  logic [NCH-1:0] invert_i,
    input  logic [NCH-1:0] enable_i,
    output logic [NCH-1:0] event_o
);

    logic [NCH-1:0] level;
    logic [NCH-1:0] level_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        // Form the gated, polarity-corrected level seen by the detector.
        always_comb begin
            level[ch] = ~(sync_i[ch] ^ invert_i[ch]) & enable_i[ch];
        end

        // Remember last cycle's level for step detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                level_q[ch] <= 1'b0;
            end else begin
                level_q[ch] <= level[ch];
            end
        end

        // Flag a rising step of the observed level.
        always_comb begin
            event_o[ch] = level[ch] & ~level_q[ch];
        end

        AST_EVENT_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            event_o[ch] |=> !event_o[ch]); // R2
    end

endmodule

// File: rtl/eint_regs.sv
`timescale 1ns/1ps
// Module: eint_regs
// Enable, inversion and flag registers with a combinational read mux and the
// per-channel request outputs. Flags set on a detector event and are cleared
// by writing 0; a set and a clear on the same edge leave the flag set.
module eint_regs
    import eint_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_i,
    input  logic [EINT_ADDR_W-1:0] addr_i,
    input  logic [NCH-1:0]         wdata_i,
    input  logic [NCH-1:0]         event_i,
    output logic [DW-1:0]          rdata_o,
    output logic [NCH-1:0]         enable_o,
    output logic [NCH-1:0]         invert_o,
    output logic [NCH-1:0]         irq_o
);

    reg_sel_e       sel;
    logic [NCH-1:0] enable_q;
    logic [NCH-1:0] invert_q;
    logic [NCH-1:0] flag_q;
    logic [NCH-1:0] flag_keep;
    logic           wr_enable;
    logic           wr_invert;
    logic           wr_flag;

    // Decode the offset once for both the write and the read side.
    always_comb begin
        sel       = decode_addr(addr_i);
        wr_enable = wr_i && (sel == SEL_ENABLE);
        wr_invert = wr_i && (sel == SEL_INVERT);
        wr_flag   = wr_i && (sel == SEL_FLAG);
    end

    // Hold the enable and inversion bits; only written bits [NCH-1:0] land.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            invert_q <= '0;
        end else begin
            if (wr_enable) enable_q <= wdata_i;
            if (wr_invert) invert_q <= wdata_i;
        end
    end

    // Mask applied by a flag write: a written 0 clears, a written 1 keeps.
    always_comb begin
        flag_keep = wr_flag ? wdata_i : {NCH{1'b1}};
    end

    // Update flags; the event OR comes last so a set beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= (flag_q & flag_keep) | event_i;
        end
    end

    // Return the selected register, zero-extended; unknown offsets read 0.
    always_comb begin
        rdata_o = '0;
        case (sel)
            SEL_ENABLE: rdata_o[NCH-1:0] = enable_q;
            SEL_INVERT: rdata_o[NCH-1:0] = invert_q;
            SEL_FLAG:   rdata_o[NCH-1:0] = flag_q;
            default:    rdata_o          = '0;
        endcase
    end

    // Drive a request while both flag and enable are set.
    always_comb begin
        irq_o = flag_q & enable_q;
    end

    assign enable_o = enable_q;
    assign invert_o = invert_q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (flag_q == '0 && enable_q == '0 && invert_q == '0)); // R1

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_FLAG_RISE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[ch]) |-> $past(event_i[ch])); // R2

        AST_CLEAR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flag && !wdata_i[ch] && !event_i[ch]) |=> !flag_q[ch]); // R3

        AST_WRITE_ONE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_flag && wdata_i[ch] && !flag_q[ch] && !event_i[ch]) |=> !flag_q[ch]); // R3

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            event_i[ch] |=> flag_q[ch]); // R8
    end

endmodule

// File: rtl/eint_ctrl.sv
`timescale 1ns/1ps
// Module: eint_ctrl (top)
// Four-channel external edge interrupt unit: synchroniser, gated polarity
// edge detector, register file and request/wake outputs. Assumes bus writes
// are single-cycle strobes and pins are asynchronous to clk. The wake output
// is pure combinational logic on register state, usable with clocks stopped.
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int unsigned NCH = 4,
    parameter int unsigned DW  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCH-1:0]         pin_i,
    input  logic                   bus_wr,
    input  logic [EINT_ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]          bus_wdata,
    output logic [DW-1:0]          bus_rdata,
    output logic [NCH-1:0]         irq_o,
    output logic                   wake_o
);

    logic [NCH-1:0] pin_sync;
    logic [NCH-1:0] enable;
    logic [NCH-1:0] invert;
    logic [NCH-1:0] edge_evt;
    logic           wdata_unused;

    // Upper write-data bits have no storage behind them.
    assign wdata_unused = ^bus_wdata[DW-1:NCH];

    eint_sync #(
        .NCH    (NCH),
        .STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    eint_edge #(
        .NCH (NCH)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_i   (pin_sync),
        .invert_i (invert),
        .enable_i (enable),
        .event_o  (edge_evt)
    );

    eint_regs #(
        .NCH (NCH),
        .DW  (DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (bus_wr),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata[NCH-1:0]),
        .event_i  (edge_evt),
        .rdata_o  (bus_rdata),
        .enable_o (enable),
        .invert_o (invert),
        .irq_o    (irq_o)
    );

    // Combine all requests into the clock-free wake line.
    always_comb begin
        wake_o = |irq_o;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[ch] |-> enable[ch]); // R4

        AST_IRQ_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(enable[ch]) && $past(irq_o[ch] == 1'b0) && bus_rdata == bus_rdata
             && !$past(bus_wr && decode_addr(bus_addr) == SEL_FLAG)
             && $past(u_regs.flag_q[ch])) |-> irq_o[ch]); // R4
    end

    AST_WAKE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> (irq_o != '0)); // R7

endmodule

// File: tb/eint_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for eint_ctrl: the driver stamps expected request values
// with their due cycle; a monitor pops and compares them at the falling edge.
module eint_ctrl_tb;

    localparam int unsigned NCH = 4;
    localparam int unsigned DW  = 32;
    localparam logic [3:0] A_EN  = 4'h0;
    localparam logic [3:0] A_INV = 4'h4;
    localparam logic [3:0] A_FLG = 4'h8;

    typedef struct {
        int          due;
        logic [3:0]  irq;
        string       req;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pin = '1;
    logic           bus_wr = 1'b0;
    logic [3:0]     bus_addr = 4'h0;
    logic [DW-1:0]  bus_wdata = '0;
    logic [DW-1:0]  bus_rdata;
    logic [NCH-1:0] irq;
    logic           wake;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];

    eint_ctrl #(.NCH(NCH), .DW(DW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq),
        .wake_o    (wake)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    // Monitor: compare request and wake lines against due scoreboard items.
    always @(negedge clk) begin
        exp_t e;
        while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            e = exp_q.pop_front();
            check(irq === e.irq, e.req, "irq_o", {28'd0, irq}, {28'd0, e.irq});
            check(wake === (|e.irq), "R7", "wake_o", {31'd0, wake}, {31'd0, |e.irq});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_at(input int d, input logic [3:0] v, input string req);
        exp_t e;
        e.due = cyc + d;
        e.irq = v;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        tick(1);
        bus_wr    = 1'b0;
        bus_addr  = A_FLG;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] expv, input string req);
        bus_addr = a;
        #1;
        check(bus_rdata === expv, req, "read", bus_rdata, expv);
        bus_addr = A_FLG;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        rd_chk(A_EN, 32'h0, "R1");
        rd_chk(A_INV, 32'h0, "R1");
        rd_chk(A_FLG, 32'h0, "R1");
        expect_at(0, 4'b0000, "R1");
        tick(1);

        // R2: enable ch0 with pin high, no event; then falling edge
        expect_at(1, 4'b0000, "R2");
        wr(A_EN, 32'h1);
        tick(2);
        rd_chk(A_FLG, 32'h0, "R2");
        pin[0] = 1'b0;
        expect_at(2, 4'b0000, "R2");
        expect_at(3, 4'b0001, "R2");
        tick(4);
        rd_chk(A_FLG, 32'h1, "R2");

        // R3: write 0 clears, write 1 leaves clear flag alone
        expect_at(1, 4'b0000, "R3");
        wr(A_FLG, 32'hFFFF_FFFE);
        rd_chk(A_FLG, 32'h0, "R3");
        wr(A_FLG, 32'hFFFF_FFFF);
        tick(1);
        rd_chk(A_FLG, 32'h0, "R3");

        // R2: rising edge with invert 0 sets nothing
        pin[0] = 1'b1;
        tick(5);
        rd_chk(A_FLG, 32'h0, "R2");
        expect_at(0, 4'b0000, "R2");

        // R2: disabled channel ignores falling edge
        pin[1] = 1'b0;
        tick(5);
        rd_chk(A_FLG, 32'h0, "R2");
        pin[1] = 1'b1;
        tick(4);

        // R5: invert 0->1 with pin high sets the flag
        expect_at(1, 4'b0000, "R5");
        expect_at(2, 4'b0001, "R5");
        wr(A_INV, 32'h1);
        tick(1);
        rd_chk(A_FLG, 32'h1, "R5");
        wr(A_FLG, 32'h0);
        tick(1);

        // R5: with invert 1, falling ignored, rising caught
        pin[0] = 1'b0;
        tick(5);
        rd_chk(A_FLG, 32'h0, "R5");
        pin[0] = 1'b1;
        expect_at(2, 4'b0000, "R5");
        expect_at(3, 4'b0001, "R5");
        tick(4);
        rd_chk(A_FLG, 32'h1, "R5");
        wr(A_FLG, 32'h0);
        tick(1);

        // R5: invert 1->0 with pin low sets the flag
        pin[0] = 1'b0;
        tick(4);
        rd_chk(A_FLG, 32'h0, "R5");
        expect_at(1, 4'b0000, "R5");
        expect_at(2, 4'b0001, "R5");
        wr(A_INV, 32'h0);
        tick(1);
        rd_chk(A_FLG, 32'h1, "R5");
        wr(A_FLG, 32'h0);
        pin[0] = 1'b1;
        tick(4);
        rd_chk(A_FLG, 32'h0, "R5");

        // R6: enabling ch2 while its pin is low sets its flag
        pin[2] = 1'b0;
        tick(4);
        rd_chk(A_FLG, 32'h0, "R6");
        expect_at(1, 4'b0000, "R6");
        expect_at(2, 4'b0100, "R6");
        wr(A_EN, 32'h5);
        tick(1);
        rd_chk(A_FLG, 32'h4, "R6");

        // R4: disabling keeps flag, re-enabling asserts at once
        expect_at(1, 4'b0000, "R4");
        wr(A_EN, 32'h1);
        rd_chk(A_FLG, 32'h4, "R4");
        pin[2] = 1'b1;
        tick(4);
        expect_at(1, 4'b0100, "R4");
        wr(A_EN, 32'h5);
        tick(2);
        expect_at(1, 4'b0000, "R3");
        wr(A_FLG, 32'h0);
        tick(1);

        // R8: event and clear write on the same edge -> flag set
        pin[0] = 1'b0;
        tick(2);
        expect_at(1, 4'b0001, "R8");
        wr(A_FLG, 32'h0);
        rd_chk(A_FLG, 32'h1, "R8");
        expect_at(1, 4'b0000, "R3");
        wr(A_FLG, 32'h0);
        tick(1);

        // R10: all enabled, two channels fall together
        wr(A_EN, 32'hF);
        tick(2);
        rd_chk(A_FLG, 32'h0, "R10");
        pin[1] = 1'b0;
        pin[3] = 1'b0;
        expect_at(3, 4'b1010, "R10");
        tick(4);
        rd_chk(A_FLG, 32'hA, "R10");
        expect_at(1, 4'b1000, "R10");
        wr(A_FLG, 32'hFFFF_FFFD);
        rd_chk(A_FLG, 32'h8, "R10");
        expect_at(1, 4'b0000, "R7");
        wr(A_FLG, 32'h0);
        tick(1);

        // R9: register map, upper bits dropped, other offsets read 0
        wr(A_EN, 32'hFFFF_FFF0);
        rd_chk(A_EN, 32'h0, "R9");
        wr(A_INV, 32'h0000_00A5);
        rd_chk(A_INV, 32'h5, "R9");
        rd_chk(4'hC, 32'h0, "R9");
        rd_chk(4'h1, 32'h0, "R9");
        tick(3);

        check(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule